// File: doc/BRIEF.md
# Up/Down Timer Counter with Clock Select

This block is an 8-bit event and interval counter. It has a mode register that sets two things: how the counter picks its direction, and which source advances it. The direction can be fixed up, fixed down, or follow an external up/down pin at run time. The clock source can be one of six taps of a free-running system-clock prescaler, the subclock divided by four, or edges of an external event pin. For the event pin, an edge-polarity input chooses whether rising or falling edges count.

A processor reaches the block through a small register port. Address 0 is the mode register and address 1 is the counter value. Writes land on the next clock edge. Reads are combinational. The counter wraps freely in both directions. All asynchronous inputs are resynchronised into the system clock domain before use.

Top module: `updown_timer`

## Requirements
- R1: After reset the counter reads 0x00 and the mode register reads 0x58, which means pin-steered direction and clock select code 000.
- R2: Mode bits 4 and 3 always read 1 and ignore writes. Bits 7, 6:5 and 2:0 read back exactly as written.
- R3: Address 0 selects the mode register and address 1 selects the counter. A write to the mode register leaves the counter value unchanged.
- R4: Direction field (mode bits 6:5) value 00 counts up and 01 counts down.
- R5: Direction field values 10 and 11 follow the up/down pin: high counts down, low counts up. Reset leaves the direction under pin control.
- R6: Counting up from 0xFF gives 0x00, and counting down from 0x00 gives 0xFF.
- R7: Clock select codes 000 to 101 advance the counter once per 8192, 2048, 512, 64, 16 and 4 system clocks respectively. Any window of N times that period holds exactly N advances.
- R8: Clock select code 110 advances the counter once for every four rising edges of the subclock input.
- R9: Clock select code 111 counts edges of the event input: rising when the polarity input is 0, falling when it is 1. A counted edge changes the counter on the third system clock edge after the input changes.
- R10: A processor write to the counter wins over a count enable in the same cycle; the written value is loaded and the count is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_addr_i | input | 1 | Register select: 0 mode, 1 counter |
| cpu_wr_i | input | 1 | Write strobe for the addressed register |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_rdata_o | output | DATA_W | Read data of the addressed register |
| subclk_i | input | 1 | Subclock, asynchronous to clk_i |
| event_i | input | 1 | External event input |
| event_fall_i | input | 1 | Event polarity: 0 rising, 1 falling |
| updown_i | input | 1 | Direction pin: 1 down, 0 up (when pin-steered) |

## Verification
The bench builds the block with its default parameters: an 8-bit counter, a 13-bit prescaler, two-stage synchronisers and a divide-by-four subclock stage. With these values even the slowest tap, one advance per 8192 cycles, fits in a single measured window, so every clock select code is measured against its true period. The sub-period timing of the event path, three edges from pin to counter, is pinned down closely enough for the bench to place a processor write on the exact cycle that an event edge lands.

// File: rtl/utmr_pkg.sv
package utmr_pkg;

    // Clock select codes; the numeric order is the decode order of the field.
    typedef enum logic [2:0] {
        CS_P8192 = 3'd0,
        CS_P2048 = 3'd1,
        CS_P512  = 3'd2,
        CS_P64   = 3'd3,
        CS_P16   = 3'd4,
        CS_P4    = 3'd5,
        CS_SUB4  = 3'd6,
        CS_EVENT = 3'd7
    } csel_e;

    // Direction codes; bit 1 hands control to the pin.
    typedef enum logic [1:0] {
        DIR_UP      = 2'b00,
        DIR_DOWN    = 2'b01,
        DIR_PIN     = 2'b10,
        DIR_PIN_ALT = 2'b11
    } dir_e;

    // Stored part of the mode register (bits 4:3 are not stored).
    typedef struct packed {
        logic  spare;
        dir_e  dir;
        csel_e csel;
    } mode_t;

    localparam int unsigned NUM_TAPS  = 6;
    localparam int unsigned MODE_BITS = 8;
    localparam logic [1:0]  MODE_FIXED_ONES = 2'b11;

    localparam mode_t MODE_RESET = '{spare: 1'b0, dir: DIR_PIN, csel: CS_P8192};

    // log2 of the divide ratio for each prescaler tap, in select-code order.
    function automatic int unsigned tap_log2(input int unsigned idx);
        case (idx)
            0:       return 13;
            1:       return 11;
            2:       return 9;
            3:       return 6;
            4:       return 4;
            default: return 2;
        endcase
    endfunction

    function automatic mode_t mode_from_bus(input logic [MODE_BITS-1:0] w);
        mode_t m;
        m.spare = w[7];
        m.dir   = dir_e'(w[6:5]);
        m.csel  = csel_e'(w[2:0]);
        return m;
    endfunction

    function automatic logic [MODE_BITS-1:0] mode_to_bus(input mode_t m);
        return {m.spare, m.dir, MODE_FIXED_ONES, m.csel};
    endfunction

endpackage

// File: rtl/utmr_prescaler.sv
module utmr_prescaler #(
    parameter int unsigned PRE_W    = 13,
    parameter int unsigned NUM_TAPS = 6
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    output logic [NUM_TAPS-1:0] tick_o
);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_state_t;

    pre_state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.cnt = s_q.cnt + PRE_W'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // A tap of ratio 2^K fires in the one cycle where its low K bits are all ones.
    for (genvar gi = 0; gi < NUM_TAPS; gi++) begin : g_tap
        localparam int unsigned TapK = utmr_pkg::tap_log2(gi);
        assign tick_o[gi] = &s_q.cnt[TapK-1:0];
    end

endmodule

// File: rtl/utmr_sync.sv
module utmr_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] prev_o
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] pipe;
        logic [WIDTH-1:0]             prev;
    } sync_state_t;

    sync_state_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.pipe[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            s_d.pipe[s] = s_q.pipe[s-1];
        end
        s_d.prev    = s_q.pipe[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sync_o = s_q.pipe[STAGES-1];
    assign prev_o = s_q.prev;

endmodule

// File: rtl/utmr_count_core.sv
module utmr_count_core #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              down_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_val_i,
    output logic [DATA_W-1:0] cnt_o
);

    typedef struct packed {
        logic [DATA_W-1:0] cnt;
    } core_state_t;

    core_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            s_d.cnt = load_val_i;
        end else if (en_i) begin
            if (down_i) begin
                s_d.cnt = s_q.cnt - DATA_W'(1);
            end else begin
                s_d.cnt = s_q.cnt + DATA_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o = s_q.cnt;

endmodule

// File: rtl/updown_timer.sv
module updown_timer #(
    parameter int unsigned DATA_W       = 8,
    parameter int unsigned PRE_W        = 13,
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned SUB_DIV_LOG2 = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cpu_addr_i,
    input  logic              cpu_wr_i,
    input  logic [DATA_W-1:0] cpu_wdata_i,
    output logic [DATA_W-1:0] cpu_rdata_o,
    input  logic              subclk_i,
    input  logic              event_i,
    input  logic              event_fall_i,
    input  logic              updown_i
);

    import utmr_pkg::*;

    localparam int unsigned SyncW  = 3;
    localparam int unsigned IdxSub = 0;
    localparam int unsigned IdxEvt = 1;
    localparam int unsigned IdxDir = 2;

    typedef struct packed {
        mode_t                   mode;
        logic [SUB_DIV_LOG2-1:0] sub_div;
    } top_state_t;

    top_state_t s_d, s_q;

    logic [NUM_TAPS-1:0] presc_tick;
    logic [SyncW-1:0]    sync_lvl;
    logic [SyncW-1:0]    sync_prev;
    logic                sub_rise;
    logic                evt_rise;
    logic                evt_fall;
    logic                evt_edge;
    logic                sub_tick;
    logic                count_en;
    logic                count_down;
    logic                cnt_load;
    logic                mode_load;
    logic [DATA_W-1:0]   cnt_q;
    logic                unused_dir_prev;

    utmr_prescaler #(
        .PRE_W    (PRE_W),
        .NUM_TAPS (NUM_TAPS)
    ) i_prescaler (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_o (presc_tick)
    );

    utmr_sync #(
        .WIDTH  (SyncW),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({updown_i, event_i, subclk_i}),
        .sync_o  (sync_lvl),
        .prev_o  (sync_prev)
    );

    assign unused_dir_prev = sync_prev[IdxDir];

    // Edge detection in the system clock domain.
    assign sub_rise = sync_lvl[IdxSub] & ~sync_prev[IdxSub];
    assign evt_rise = sync_lvl[IdxEvt] & ~sync_prev[IdxEvt];
    assign evt_fall = ~sync_lvl[IdxEvt] & sync_prev[IdxEvt];
    assign evt_edge = event_fall_i ? evt_fall : evt_rise;

    // Subclock divider: one enable per full wrap of the edge counter.
    assign sub_tick = sub_rise & (&s_q.sub_div);

    assign cnt_load  = cpu_wr_i & cpu_addr_i;
    assign mode_load = cpu_wr_i & ~cpu_addr_i;

    always_comb begin
        s_d = s_q;

        if (sub_rise) begin
            s_d.sub_div = s_q.sub_div + SUB_DIV_LOG2'(1);
        end

        if (mode_load) begin
            s_d.mode = mode_from_bus(cpu_wdata_i[MODE_BITS-1:0]);
        end
    end

    // Count source selection.
    always_comb begin
        unique case (s_q.mode.csel)
            CS_P8192: count_en = presc_tick[0];
            CS_P2048: count_en = presc_tick[1];
            CS_P512:  count_en = presc_tick[2];
            CS_P64:   count_en = presc_tick[3];
            CS_P16:   count_en = presc_tick[4];
            CS_P4:    count_en = presc_tick[5];
            CS_SUB4:  count_en = sub_tick;
            CS_EVENT: count_en = evt_edge;
            default:  count_en = 1'b0;
        endcase
    end

    // Direction: bit 1 of the field selects the pin, otherwise bit 0 is the direction.
    always_comb begin
        if (s_q.mode.dir[1]) begin
            count_down = sync_lvl[IdxDir];
        end else begin
            count_down = s_q.mode.dir[0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.mode    <= MODE_RESET;
            s_q.sub_div <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    utmr_count_core #(
        .DATA_W (DATA_W)
    ) i_count_core (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_i       (count_en),
        .down_i     (count_down),
        .load_i     (cnt_load),
        .load_val_i (cpu_wdata_i),
        .cnt_o      (cnt_q)
    );

    always_comb begin
        if (cpu_addr_i) begin
            cpu_rdata_o = cnt_q;
        end else begin
            cpu_rdata_o = DATA_W'(mode_to_bus(s_q.mode));
        end
    end

endmodule

// File: rtl/utmr_checker.sv
module utmr_checker #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              cpu_addr_i,
    input logic              cpu_wr_i,
    input logic [DATA_W-1:0] cpu_wdata_i,
    input logic [DATA_W-1:0] cpu_rdata_i,
    input logic [DATA_W-1:0] cnt_i,
    input logic              count_en_i,
    input logic              count_down_i
);

    logic wr_cnt;
    assign wr_cnt = cpu_wr_i & cpu_addr_i;

    // R10: a counter write is taken even when a count enable coincides.
    p_write_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_cnt |=> (cnt_i == $past(cpu_wdata_i)));

    // R6: up step wraps modulo 2^DATA_W.
    p_step_up_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (count_en_i && !count_down_i && !wr_cnt) |=> (cnt_i == $past(cnt_i) + DATA_W'(1)));

    // R6: down step wraps modulo 2^DATA_W.
    p_step_down_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (count_en_i && count_down_i && !wr_cnt) |=> (cnt_i == $past(cnt_i) - DATA_W'(1)));

    // R7: without an enable or a write the counter holds.
    p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!count_en_i && !wr_cnt) |=> $stable(cnt_i));

    // R2: the two fixed mode bits always read as ones.
    p_fixed_ones_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cpu_addr_i |-> (cpu_rdata_i[4:3] == 2'b11));

    // R3: a mode write leaves the counter alone unless it is also counting.
    p_mode_wr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cpu_wr_i && !cpu_addr_i && !count_en_i) |=> $stable(cnt_i));

endmodule

bind updown_timer utmr_checker #(
    .DATA_W (DATA_W)
) i_utmr_checker (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cpu_addr_i   (cpu_addr_i),
    .cpu_wr_i     (cpu_wr_i),
    .cpu_wdata_i  (cpu_wdata_i),
    .cpu_rdata_i  (cpu_rdata_o),
    .cnt_i        (cnt_q),
    .count_en_i   (count_en),
    .count_down_i (count_down)
);

// File: tb/test_updown_timer.sv
module test_updown_timer;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_addr = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       subclk = 1'b0;
    logic       evt = 1'b0;
    logic       evt_fall = 1'b0;
    logic       updown = 1'b0;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    event     sample_ev;

    always #2.5 clk = ~clk;

    updown_timer i_updown_timer (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .cpu_addr_i   (cpu_addr),
        .cpu_wr_i     (cpu_wr),
        .cpu_wdata_i  (cpu_wdata),
        .cpu_rdata_o  (cpu_rdata),
        .subclk_i     (subclk),
        .event_i      (evt),
        .event_fall_i (evt_fall),
        .updown_i     (updown)
    );

    // Monitor: pops expected items and compares against the read port.
    initial begin
        forever begin
            @(sample_ev);
            while (sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                n_checks++;
                if (cpu_rdata !== it.exp) begin
                    n_errors++;
                    $display("FAIL %s: actual 0x%02h expected 0x%02h", it.tag, cpu_rdata, it.exp);
                end
            end
        end
    end

    // Driver side of the scoreboard.
    task automatic expect_rd(input logic a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        cpu_addr = a;
        #0.5;
        sb_q.push_back('{exp: exp, tag: tag});
        -> sample_ev;
        #0.5;
    endtask

    task automatic cpu_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr  = a;
        cpu_wdata = d;
        cpu_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cpu_wr    = 1'b0;
    endtask

    task automatic evt_pulse();
        @(negedge clk);
        evt = 1'b1;
        repeat (6) @(negedge clk);
        evt = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic sub_pulse();
        @(negedge clk);
        subclk = 1'b1;
        repeat (5) @(negedge clk);
        subclk = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    // Measures one prescaler tap over a window of n periods from a fresh zero.
    task automatic measure_tap(input logic [2:0] code, input int period, input int n, input string tag);
        cpu_write(1'b0, {5'b00000, code});
        cpu_write(1'b1, 8'h00);
        repeat (period * n) @(posedge clk);
        expect_rd(1'b1, 8'(n), tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog R1..: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values.
        expect_rd(1'b0, 8'h58, "R1 mode after reset");
        expect_rd(1'b1, 8'h00, "R1 counter after reset");

        // R7 with reset select /8192, R5 pin low counts up.
        cpu_write(1'b1, 8'h00);
        repeat (8192) @(posedge clk);
        expect_rd(1'b1, 8'h01, "R7 /8192 reset select, R5 pin low up");

        // R2: readback of mode bits.
        cpu_write(1'b0, 8'hA5);
        expect_rd(1'b0, 8'hBD, "R2 mode readback 0xA5");
        cpu_write(1'b0, 8'h00);
        expect_rd(1'b0, 8'h18, "R2 mode readback 0x00");

        // R7: remaining prescaler taps.
        measure_tap(3'd1, 2048, 2,  "R7 /2048");
        measure_tap(3'd2, 512,  10, "R7 /512");
        measure_tap(3'd3, 64,   10, "R7 /64");
        measure_tap(3'd4, 16,   10, "R7 /16");
        measure_tap(3'd5, 4,    10, "R7 /4");

        // R4: fixed down on /4.
        cpu_write(1'b0, 8'h25);
        cpu_write(1'b1, 8'h80);
        repeat (40) @(posedge clk);
        expect_rd(1'b1, 8'h76, "R4 fixed down");

        // R9: rising event edges.
        cpu_write(1'b0, 8'h07);
        cpu_write(1'b1, 8'h10);
        expect_rd(1'b1, 8'h10, "R3 counter write readback");
        for (int i = 0; i < 5; i++) evt_pulse();
        expect_rd(1'b1, 8'h15, "R9 five rising edges");

        // R9: falling polarity.
        evt_fall = 1'b1;
        @(negedge clk);
        evt = 1'b1;
        repeat (6) @(negedge clk);
        expect_rd(1'b1, 8'h15, "R9 rise ignored in falling mode");
        evt = 1'b0;
        repeat (6) @(negedge clk);
        expect_rd(1'b1, 8'h16, "R9 falling edge counted");
        evt_fall = 1'b0;

        // R6: wrap in both directions.
        cpu_write(1'b1, 8'hFF);
        evt_pulse();
        expect_rd(1'b1, 8'h00, "R6 up wrap");
        cpu_write(1'b0, 8'h27);
        evt_pulse();
        expect_rd(1'b1, 8'hFF, "R6 down wrap");

        // R5: pin-steered direction.
        cpu_write(1'b0, 8'h47);
        updown = 1'b1;
        repeat (4) @(negedge clk);
        cpu_write(1'b1, 8'h40);
        for (int i = 0; i < 3; i++) evt_pulse();
        expect_rd(1'b1, 8'h3D, "R5 pin high down");
        updown = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 2; i++) evt_pulse();
        expect_rd(1'b1, 8'h3F, "R5 pin low up");
        cpu_write(1'b0, 8'h67);
        updown = 1'b1;
        repeat (4) @(negedge clk);
        evt_pulse();
        expect_rd(1'b1, 8'h3E, "R5 field 11 pin high down");
        updown = 1'b0;

        // R3: mode write leaves counter.
        cpu_write(1'b0, 8'h07);
        expect_rd(1'b1, 8'h3E, "R3 mode write keeps counter");
        expect_rd(1'b0, 8'h1F, "R3 mode register at address 0");

        // R8: subclock divided by four.
        cpu_write(1'b0, 8'h06);
        cpu_write(1'b1, 8'h20);
        for (int i = 0; i < 8; i++) sub_pulse();
        expect_rd(1'b1, 8'h22, "R8 eight subclock edges");
        for (int i = 0; i < 4; i++) sub_pulse();
        expect_rd(1'b1, 8'h23, "R8 four more subclock edges");

        // R10: write coincides with an event enable (third edge after input change).
        cpu_write(1'b0, 8'h07);
        cpu_write(1'b1, 8'h50);
        @(negedge clk);
        evt = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        cpu_addr  = 1'b1;
        cpu_wdata = 8'h90;
        cpu_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cpu_wr = 1'b0;
        expect_rd(1'b1, 8'h90, "R10 write wins over count");
        evt = 1'b0;
        repeat (6) @(negedge clk);
        expect_rd(1'b1, 8'h90, "R10 no late count");

        // R9: latency of exactly three edges.
        @(negedge clk);
        evt = 1'b1;
        @(posedge clk);
        @(posedge clk);
        expect_rd(1'b1, 8'h90, "R9 not yet counted after two edges");
        expect_rd(1'b1, 8'h91, "R9 counted at third edge");
        evt = 1'b0;

        finished = 1'b1;
        repeat (2) @(negedge clk);
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule